// File: doc/BRIEF.md
# Shared Counter with Per-Processor Compare Timer

This block holds one shared counter and, for each processor, a compare register with its own interrupt state. The counter advances by one every clock while it runs. When it equals a processor's compare value, that processor's compare-pending flag is set. The flag drives that processor's interrupt output, gated by a local mask bit and by a routing flag in the compare map. The same map also supplies the pin number that is presented beside the interrupt.

Software reaches the block over a simple register bus. Each request carries the index of the requesting processor. Each processor has a "local" window that addresses its own registers. It also has an "other" window that addresses the registers of whichever processor its redirect pointer names, so one processor can set up another processor's timer. A stop control freezes the counter, and the counter can only be loaded while it is frozen. A read-only user alias also exposes the counter. The upper halves of the counter and the compare values are not stored, and reads of them return zero.

Top module: `shared_cmp_timer`

## Requirements
- R1: Address bits [5:4] select a section: 0 shared, 1 local window, 2 other window, 3 user alias; bits [3:0] are the offset. Shared offset 0 is the configuration word, whose bit 0 is the stop bit. While the stop bit is 0 the counter (shared offset 1) rises by exactly one per clock; while it is 1 the counter holds its value. The stop bit reads back as written.
- R2: A write to shared offset 1 loads the counter only while the stop bit is 1; while the counter runs the write is ignored and counting continues unchanged.
- R3: If the counter is running and equals a processor's compare value, that processor's pending flag is set at the next clock edge. The flag reads as bit 1 of window offset 3. It stays set until the compare is written again. No match is taken while the counter is stopped.
- R4: A write to window offset 7 loads the compare value of the addressed processor and clears its pending flag at the same edge; the interrupt output falls right after that edge.
- R5: A processor's cmp_irq is high exactly when its pending flag, bit 1 of its mask and bit 31 of its compare map (window offset 4) are all set. Its cmp_pin field, bits [3i+2:3i], equals the map's pin number, which sits in map bits [5:0].
- R6: The 6-bit mask reads at window offset 0. A 1 written at offset 1 sets that mask bit, and a 1 written at offset 2 clears it; 0 bits leave the mask unchanged.
- R7: A compare-map write whose pin field (bits [5:0]) exceeds MAX_PIN (default 5) is discarded whole; otherwise flag and pin are stored.
- R8: The redirect pointer at window offset 5 accepts only values below NUM_CPU and ignores others; reads and writes through the other window act on the processor it names.
- R9: Window offset 6 reads the index of the processor that the access addresses.
- R10: After reset the counter is 0 and running, every compare is 0xFFFFFFFF, every mask is 0x32, every compare map is 0x80000000, and pending flags, pointers, interrupts and pins are 0.
- R11: User offset 0 reads the counter and ignores writes; user offset 1, shared offset 2 and window offset 8 read as zero.
- R12: Read data appears on bus_rdata one clock after the read request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register access request, one per clock |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 6 | Section in [5:4], offset in [3:0] |
| bus_cpu | input | CPU_W (2) | Index of the requesting processor |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cmp_irq | output | NUM_CPU (4) | Compare interrupt per processor |
| cmp_pin | output | NUM_CPU*PIN_W (12) | Mapped pin number per processor |

## Verification
Writes take effect at the edge that samples them. Mask, map and compare changes therefore show on cmp_irq and cmp_pin at the next falling edge. Read data for a request shows up one falling edge later and reflects the state before the sampling edge. A compare match lags by one further edge: once a start write is accepted, the counter value after the k-th following edge is the loaded value plus k, so a compare N steps above that value raises the interrupt at the (N+1)-th falling edge. The bench drives and samples only on falling edges, counts edges from each start write, and checks every processor's interrupt at every step of a sweep in which the compare offsets are staggered.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 6;
  localparam int MASK_W  = 6;
  localparam int CMP_BIT = 1;
  localparam int FLAG_BIT = 31;
  localparam int PIN_FIELD_W = 6;
  localparam logic [MASK_W-1:0] MASK_RST = 6'h32;

  typedef enum logic [1:0] {
    SEC_SHARED = 2'd0,
    SEC_LOCAL  = 2'd1,
    SEC_OTHER  = 2'd2,
    SEC_USER   = 2'd3
  } sec_e;

  localparam logic [3:0] SH_CFG    = 4'd0;
  localparam logic [3:0] SH_CNT    = 4'd1;
  localparam logic [3:0] SH_CNT_HI = 4'd2;

  localparam logic [3:0] WN_MASK   = 4'd0;
  localparam logic [3:0] WN_MSET   = 4'd1;
  localparam logic [3:0] WN_MCLR   = 4'd2;
  localparam logic [3:0] WN_PEND   = 4'd3;
  localparam logic [3:0] WN_MAP    = 4'd4;
  localparam logic [3:0] WN_PTR    = 4'd5;
  localparam logic [3:0] WN_IDENT  = 4'd6;
  localparam logic [3:0] WN_CMP    = 4'd7;
  localparam logic [3:0] WN_CMP_HI = 4'd8;

  localparam logic [3:0] US_CNT    = 4'd0;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_MSET = 3'd1,
    OP_MCLR = 3'd2,
    OP_MAP  = 3'd3,
    OP_PTR  = 3'd4,
    OP_CMP  = 3'd5
  } slot_op_e;
endpackage

// File: rtl/sct_counter.sv
module sct_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             stop_wr,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic             stop_q,
  output logic [CNT_W-1:0] count_q
);
  logic             stop_d;
  logic [CNT_W-1:0] count_d;

  always_comb begin
    stop_d  = cfg_we ? stop_wr : stop_q;
    count_d = count_q;
    if (!stop_q) begin
      count_d = count_q + CNT_W'(1);
    end else if (cnt_we) begin
      count_d = cnt_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q  <= 1'b0;
      count_q <= '0;
    end else begin
      stop_q  <= stop_d;
      count_q <= count_d;
    end
  end

  assert_run_steps_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_q |=> count_q == $past(count_q) + CNT_W'(1));

  assert_halt_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && !cnt_we) |=> $stable(count_q));

  assert_load_when_stopped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && cnt_we) |=> count_q == $past(cnt_wdata));
endmodule

// File: rtl/sct_slot.sv
module sct_slot
  import sct_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CNT_W   = 32,
  parameter int MAX_PIN = 5,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int PIN_W  = (MAX_PIN > 0) ? $clog2(MAX_PIN + 1) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  slot_op_e          op,
  input  logic [DATA_W-1:0] wdata,
  input  logic              running,
  input  logic [CNT_W-1:0]  count,
  output logic [MASK_W-1:0] mask_q,
  output logic              pend_q,
  output logic              flag_q,
  output logic [PIN_W-1:0]  pin_q,
  output logic [CPU_W-1:0]  ptr_q,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              irq
);
  logic [MASK_W-1:0] mask_d;
  logic              pend_d;
  logic              flag_d;
  logic [PIN_W-1:0]  pin_d;
  logic [CPU_W-1:0]  ptr_d;
  logic [CNT_W-1:0]  cmp_d;
  logic              hit;
  logic              wr_cmp;
  logic              pin_ok;
  logic              ptr_ok;

  always_comb begin
    hit    = running && (count == cmp_q);
    wr_cmp = sel && (op == OP_CMP);
    pin_ok = wdata[PIN_FIELD_W-1:0] <= PIN_FIELD_W'(MAX_PIN);
    ptr_ok = wdata < DATA_W'(NUM_CPU);

    mask_d = mask_q;
    flag_d = flag_q;
    pin_d  = pin_q;
    ptr_d  = ptr_q;
    cmp_d  = cmp_q;
    if (sel) begin
      unique case (op)
        OP_MSET: mask_d = mask_q | wdata[MASK_W-1:0];
        OP_MCLR: mask_d = mask_q & ~wdata[MASK_W-1:0];
        OP_MAP: begin
          if (pin_ok) begin
            flag_d = wdata[FLAG_BIT];
            pin_d  = wdata[PIN_W-1:0];
          end
        end
        OP_PTR: begin
          if (ptr_ok) ptr_d = wdata[CPU_W-1:0];
        end
        OP_CMP:  cmp_d = wdata[CNT_W-1:0];
        default: ;
      endcase
    end

    if (wr_cmp) begin
      pend_d = 1'b0;
    end else if (hit) begin
      pend_d = 1'b1;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= MASK_RST;
      pend_q <= 1'b0;
      flag_q <= 1'b1;
      pin_q  <= '0;
      ptr_q  <= '0;
      cmp_q  <= '1;
    end else begin
      mask_q <= mask_d;
      pend_q <= pend_d;
      flag_q <= flag_d;
      pin_q  <= pin_d;
      ptr_q  <= ptr_d;
      cmp_q  <= cmp_d;
    end
  end

  assign irq = pend_q && mask_q[CMP_BIT] && flag_q;

  assert_cmp_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_CMP) |=> (!pend_q && cmp_q == $past(wdata[CNT_W-1:0])));

  assert_pend_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !(sel && op == OP_CMP)) |=> pend_q);

  assert_no_match_stopped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !pend_q) |=> !pend_q);

  assert_bad_pin_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && op == OP_MAP && wdata[PIN_FIELD_W-1:0] > PIN_FIELD_W'(MAX_PIN))
      |=> ($stable(pin_q) && $stable(flag_q)));

  assert_ptr_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < NUM_CPU);
endmodule

// File: rtl/sct_regbus.sv
module sct_regbus
  import sct_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CNT_W   = 32,
  parameter int PIN_W   = 3,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              bus_valid,
  input  logic                              bus_write,
  input  logic [ADDR_W-1:0]                 bus_addr,
  input  logic [CPU_W-1:0]                  bus_cpu,
  input  logic                              stop_q,
  input  logic [CNT_W-1:0]                  count_q,
  input  logic [NUM_CPU-1:0][MASK_W-1:0]    mask_a,
  input  logic [NUM_CPU-1:0]                pend_a,
  input  logic [NUM_CPU-1:0]                flag_a,
  input  logic [NUM_CPU-1:0][PIN_W-1:0]     pin_a,
  input  logic [NUM_CPU-1:0][CPU_W-1:0]     ptr_a,
  input  logic [NUM_CPU-1:0][CNT_W-1:0]     cmp_a,
  output logic                              cfg_we,
  output logic                              cnt_we,
  output logic [NUM_CPU-1:0]                slot_sel,
  output slot_op_e                          slot_op,
  output logic [DATA_W-1:0]                 bus_rdata
);
  sec_e              sec;
  logic [3:0]        ofs;
  logic              cpu_ok;
  logic [CPU_W-1:0]  target;
  logic              win;
  logic              rd_en;
  logic [DATA_W-1:0] rd_d;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    sec    = sec_e'(bus_addr[5:4]);
    ofs    = bus_addr[3:0];
    cpu_ok = int'(bus_cpu) < NUM_CPU;
    win    = (sec == SEC_LOCAL) || (sec == SEC_OTHER);
    target = bus_cpu;
    if (sec == SEC_OTHER && cpu_ok) target = ptr_a[bus_cpu];
  end

  // write decode
  always_comb begin
    cfg_we  = 1'b0;
    cnt_we  = 1'b0;
    slot_op = OP_NONE;
    if (bus_valid && bus_write) begin
      if (sec == SEC_SHARED) begin
        cfg_we = (ofs == SH_CFG);
        cnt_we = (ofs == SH_CNT);
      end else if (win && cpu_ok) begin
        unique case (ofs)
          WN_MSET: slot_op = OP_MSET;
          WN_MCLR: slot_op = OP_MCLR;
          WN_MAP:  slot_op = OP_MAP;
          WN_PTR:  slot_op = OP_PTR;
          WN_CMP:  slot_op = OP_CMP;
          default: slot_op = OP_NONE;
        endcase
      end
    end
  end

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_sel
    assign slot_sel[g] = (slot_op != OP_NONE) && (target == CPU_W'(g));
  end

  // read mux
  always_comb begin
    rd_d = '0;
    unique case (sec)
      SEC_SHARED: begin
        if (ofs == SH_CFG) rd_d[0] = stop_q;
        else if (ofs == SH_CNT) rd_d = DATA_W'(count_q);
      end
      SEC_LOCAL, SEC_OTHER: begin
        if (cpu_ok) begin
          unique case (ofs)
            WN_MASK:  rd_d = DATA_W'(mask_a[target]);
            WN_PEND:  rd_d[CMP_BIT] = pend_a[target];
            WN_MAP: begin
              rd_d[FLAG_BIT]  = flag_a[target];
              rd_d[PIN_W-1:0] = pin_a[target];
            end
            WN_PTR:   rd_d = DATA_W'(ptr_a[target]);
            WN_IDENT: rd_d = DATA_W'(target);
            WN_CMP:   rd_d = DATA_W'(cmp_a[target]);
            default:  rd_d = '0;
          endcase
        end
      end
      SEC_USER: begin
        if (ofs == US_CNT) rd_d = DATA_W'(count_q);
      end
      default: rd_d = '0;
    endcase
  end

  always_comb begin
    rd_en   = bus_valid && !bus_write;
    rdata_d = rd_en ? rd_d : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  assert_single_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_sel));

  assert_sel_needs_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_sel != '0) |-> (bus_valid && bus_write));

  assert_cfg_readback_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_write && sec == SEC_SHARED && ofs == SH_CFG)
      |=> bus_rdata == DATA_W'($past(stop_q)));

  assert_rdata_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

// File: rtl/shared_cmp_timer.sv
module shared_cmp_timer
  import sct_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int CNT_W   = 32,
  parameter int MAX_PIN = 5,
  localparam int CPU_W  = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
  localparam int PIN_W  = (MAX_PIN > 0) ? $clog2(MAX_PIN + 1) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_valid,
  input  logic                     bus_write,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [CPU_W-1:0]         bus_cpu,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [NUM_CPU-1:0]       cmp_irq,
  output logic [NUM_CPU*PIN_W-1:0] cmp_pin
);
  logic [1:0]                   rst_sync_q;
  logic                         core_rst_n;
  logic                         cfg_we;
  logic                         cnt_we;
  logic                         stop_q;
  logic [CNT_W-1:0]             count_q;
  logic [NUM_CPU-1:0]           slot_sel;
  slot_op_e                     slot_op;
  logic [NUM_CPU-1:0][MASK_W-1:0] mask_a;
  logic [NUM_CPU-1:0]           pend_a;
  logic [NUM_CPU-1:0]           flag_a;
  logic [NUM_CPU-1:0][PIN_W-1:0] pin_a;
  logic [NUM_CPU-1:0][CPU_W-1:0] ptr_a;
  logic [NUM_CPU-1:0][CNT_W-1:0] cmp_a;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  sct_counter #(.CNT_W(CNT_W)) u_counter (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .cfg_we    (cfg_we),
    .stop_wr   (bus_wdata[0]),
    .cnt_we    (cnt_we),
    .cnt_wdata (bus_wdata[CNT_W-1:0]),
    .stop_q    (stop_q),
    .count_q   (count_q)
  );

  sct_regbus #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W), .PIN_W(PIN_W)) u_regbus (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_cpu   (bus_cpu),
    .stop_q    (stop_q),
    .count_q   (count_q),
    .mask_a    (mask_a),
    .pend_a    (pend_a),
    .flag_a    (flag_a),
    .pin_a     (pin_a),
    .ptr_a     (ptr_a),
    .cmp_a     (cmp_a),
    .cfg_we    (cfg_we),
    .cnt_we    (cnt_we),
    .slot_sel  (slot_sel),
    .slot_op   (slot_op),
    .bus_rdata (bus_rdata)
  );

  for (genvar g = 0; g < NUM_CPU; g++) begin : g_slot
    sct_slot #(.NUM_CPU(NUM_CPU), .CNT_W(CNT_W), .MAX_PIN(MAX_PIN)) u_slot (
      .clk     (clk),
      .rst_n   (core_rst_n),
      .sel     (slot_sel[g]),
      .op      (slot_op),
      .wdata   (bus_wdata),
      .running (!stop_q),
      .count   (count_q),
      .mask_q  (mask_a[g]),
      .pend_q  (pend_a[g]),
      .flag_q  (flag_a[g]),
      .pin_q   (pin_a[g]),
      .ptr_q   (ptr_a[g]),
      .cmp_q   (cmp_a[g]),
      .irq     (cmp_irq[g])
    );
    assign cmp_pin[g*PIN_W +: PIN_W] = pin_a[g];
  end
endmodule

// File: tb/shared_cmp_timer_test.sv
module shared_cmp_timer_test;
  localparam int NCPU = 4;
  localparam int MAXP = 5;
  localparam logic [1:0] S_SH = 2'd0, S_LO = 2'd1, S_OT = 2'd2, S_US = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_valid, bus_write;
  logic [5:0]  bus_addr;
  logic [1:0]  bus_cpu;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  cmp_irq;
  logic [11:0] cmp_pin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  shared_cmp_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_cpu(bus_cpu), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cmp_irq(cmp_irq), .cmp_pin(cmp_pin)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] ad(input logic [1:0] s, input int o);
    return {s, 4'(o)};
  endfunction

  task automatic wr(input int cpu, input logic [5:0] a, input logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b1; bus_cpu = 2'(cpu); bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input int cpu, input logic [5:0] a, output logic [31:0] d);
    bus_valid = 1'b1; bus_write = 1'b0; bus_cpu = 2'(cpu); bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, v;
    int last_pin;
    rst_n = 1'b0; bus_valid = 1'b0; bus_write = 1'b0;
    bus_addr = '0; bus_cpu = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    chk("R10 irq", 32'(cmp_irq), 32'h0);
    chk("R10 pins", 32'(cmp_pin), 32'h0);
    rd(0, ad(S_SH, 0), v); chk("R10 config", v, 32'h0);
    for (int c = 0; c < NCPU; c++) begin
      rd(c, ad(S_LO, 0), v); chk("R10 mask", v, 32'h32);
      rd(c, ad(S_LO, 4), v); chk("R10 map", v, 32'h8000_0000);
      rd(c, ad(S_LO, 7), v); chk("R10 compare", v, 32'hFFFF_FFFF);
      rd(c, ad(S_LO, 5), v); chk("R10 pointer", v, 32'h0);
      rd(c, ad(S_LO, 3), v); chk("R10 pending", v, 32'h0);
    end

    // R1 running counter steps by one per read cycle (R12 read timing)
    for (int i = 0; i < 3; i++) begin
      rd(0, ad(S_SH, 1), a); rd(1, ad(S_SH, 1), b);
      chk("R1 step", b, a + 32'd1);
    end

    // R2 write while running ignored
    rd(0, ad(S_SH, 1), a);
    wr(0, ad(S_SH, 1), 32'h0000_1234);
    rd(0, ad(S_SH, 1), b);
    chk("R2 running write ignored", b, a + 32'd2);

    // R1 stop
    wr(0, ad(S_SH, 0), 32'h1);
    rd(0, ad(S_SH, 0), v); chk("R1 stop readback", v, 32'h1);
    rd(0, ad(S_SH, 1), a);
    repeat (5) @(negedge clk);
    rd(0, ad(S_SH, 1), b); chk("R1 halted", b, a);

    // R2 load while stopped
    wr(2, ad(S_SH, 1), 32'hABCD_0000);
    rd(0, ad(S_SH, 1), v); chk("R2 load", v, 32'hABCD_0000);

    // R11 alias and upper halves
    rd(3, ad(S_US, 0), v); chk("R11 alias", v, 32'hABCD_0000);
    wr(3, ad(S_US, 0), 32'h55);
    rd(0, ad(S_SH, 1), v); chk("R11 alias write ignored", v, 32'hABCD_0000);
    rd(0, ad(S_US, 1), v); chk("R11 alias upper", v, 32'h0);
    rd(0, ad(S_SH, 2), v); chk("R11 counter upper", v, 32'h0);
    rd(1, ad(S_LO, 8), v); chk("R11 compare upper", v, 32'h0);

    // R1 restart
    wr(0, ad(S_SH, 0), 32'h0);
    rd(0, ad(S_SH, 1), a); chk("R1 restart first", a, 32'hABCD_0000);
    rd(0, ad(S_SH, 1), b); chk("R1 restart next", b, 32'hABCD_0001);

    // R3 staggered matches across processors
    wr(0, ad(S_SH, 0), 32'h1);
    wr(0, ad(S_SH, 1), 32'd100);
    for (int c = 0; c < NCPU; c++) wr(c, ad(S_LO, 7), 32'(100 + 3 * (c + 1)));
    wr(0, ad(S_SH, 0), 32'h0);
    chk("R3 no early match", 32'(cmp_irq), 32'h0);
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      for (int c = 0; c < NCPU; c++)
        chk("R3 match timing", 32'(cmp_irq[c]), 32'(k >= 3 * (c + 1) + 1));
    end
    rd(0, ad(S_LO, 3), v); chk("R3 pending bit", v, 32'h2);
    repeat (20) @(negedge clk);
    chk("R3 sticky", 32'(cmp_irq), 32'hF);

    // R5 gating
    wr(1, ad(S_LO, 2), 32'h2); chk("R5 mask gate", 32'(cmp_irq), 32'hD);
    wr(1, ad(S_LO, 1), 32'h2); chk("R5 mask ungate", 32'(cmp_irq), 32'hF);
    wr(1, ad(S_LO, 4), 32'h3);
    chk("R5 flag gate", 32'(cmp_irq), 32'hD);
    chk("R5 pin out", 32'(cmp_pin[5:3]), 32'h3);
    wr(1, ad(S_LO, 4), 32'h8000_0000); chk("R5 flag ungate", 32'(cmp_irq), 32'hF);

    // R4 compare write clears
    for (int c = 0; c < NCPU; c++) begin
      wr(c, ad(S_LO, 7), 32'hFFFF_FFF0);
      chk("R4 irq cleared", 32'(cmp_irq[c]), 32'h0);
      rd(c, ad(S_LO, 3), v); chk("R4 pending cleared", v, 32'h0);
      rd(c, ad(S_LO, 7), v); chk("R4 compare stored", v, 32'hFFFF_FFF0);
    end

    // R3 no match while stopped, then match at start
    wr(0, ad(S_SH, 0), 32'h1);
    wr(0, ad(S_SH, 1), 32'd500);
    wr(0, ad(S_LO, 7), 32'd500);
    repeat (5) @(negedge clk);
    chk("R3 stopped no match", 32'(cmp_irq[0]), 32'h0);
    wr(0, ad(S_SH, 0), 32'h0);
    chk("R3 start edge", 32'(cmp_irq[0]), 32'h0);
    @(negedge clk);
    chk("R3 match after start", 32'(cmp_irq[0]), 32'h1);
    wr(0, ad(S_LO, 7), 32'hFFFF_FFF0);

    // R6 mask set/clear sweep
    for (int c = 0; c < NCPU; c++) begin
      wr(c, ad(S_LO, 2), 32'h3F); rd(c, ad(S_LO, 0), v); chk("R6 clear all", v, 32'h00);
      wr(c, ad(S_LO, 1), 32'h15); rd(c, ad(S_LO, 0), v); chk("R6 set", v, 32'h15);
      wr(c, ad(S_LO, 1), 32'h0A); rd(c, ad(S_LO, 0), v); chk("R6 set more", v, 32'h1F);
      wr(c, ad(S_LO, 2), 32'h11); rd(c, ad(S_LO, 0), v); chk("R6 clear some", v, 32'h0E);
      wr(c, ad(S_LO, 2), 32'h3F); wr(c, ad(S_LO, 1), 32'h32);
    end

    // R7 pin sweep
    for (int c = 0; c < NCPU; c++) begin
      last_pin = 0;
      for (int p = 0; p < 8; p++) begin
        wr(c, ad(S_LO, 4), 32'h8000_0000 | 32'(p));
        if (p <= MAXP) last_pin = p;
        chk("R7 pin output", 32'(cmp_pin[c*3 +: 3]), 32'(last_pin));
        rd(c, ad(S_LO, 4), v); chk("R7 map readback", v, 32'h8000_0000 | 32'(last_pin));
      end
      wr(c, ad(S_LO, 4), 32'h0000_0007);
      rd(c, ad(S_LO, 4), v); chk("R7 discard keeps flag", v, 32'h8000_0005);
      wr(c, ad(S_LO, 4), 32'h8000_0000);
    end

    // R8 / R9 pointer and identity sweep
    for (int r = 0; r < NCPU; r++) begin
      for (int p = 0; p < NCPU; p++) begin
        wr(r, ad(S_LO, 5), 32'(p));
        rd(r, ad(S_OT, 6), v); chk("R9 other ident", v, 32'(p));
        rd(r, ad(S_LO, 6), v); chk("R9 local ident", v, 32'(r));
      end
      wr(r, ad(S_LO, 5), 32'd4);
      rd(r, ad(S_LO, 5), v); chk("R8 pointer bound", v, 32'd3);
      wr(r, ad(S_LO, 5), 32'hFFFF_FFFF);
      rd(r, ad(S_LO, 5), v); chk("R8 pointer huge", v, 32'd3);
    end
    wr(0, ad(S_LO, 5), 32'd2);
    wr(0, ad(S_OT, 2), 32'h10);
    rd(2, ad(S_LO, 0), v); chk("R8 other mask write", v, 32'h22);
    rd(0, ad(S_LO, 0), v); chk("R8 own mask untouched", v, 32'h32);
    wr(0, ad(S_OT, 7), 32'h1357_9BDF);
    rd(2, ad(S_LO, 7), v); chk("R8 other compare write", v, 32'h1357_9BDF);
    rd(0, ad(S_OT, 7), v); chk("R8 other compare read", v, 32'h1357_9BDF);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule